// File: doc/BRIEF.md
# Linked Descriptor Packet Queue Engine

This block looks after one queue of chained DMA descriptors kept in a shared SRAM. It holds two byte pointers, the current head and a fixed terminator, and the queue counts as empty whenever they are equal. A packet may be split over several descriptors. The first descriptor of a packet points at the packet's last descriptor, so the engine can step past a whole packet with two reads.

Software or a sequencer sends one command at a time through a request/acknowledge port. The commands are: two conditional dequeues that test the head's 2-bit ownership code, a rearm that hands a descriptor back to hardware, a reinitialise that makes a receive-side descriptor ready for reuse, and a length count. Every descriptor access goes through a 32-bit, word-addressed memory port with a ready handshake. A dequeue returns the byte address of the descriptor it removed.

Top module: `desc_queue_engine`

## Requirements
- R1: After reset, head and terminator both equal the reset pointer (default 0), `empty` is 1, `busy` is 0 and `cmd_ready` is 1.
- R2: A dequeue (op 0 or 1) on an empty queue finishes with `rsp_found`=0 and `rsp_addr`=0, and makes no memory access.
- R3: A descriptor is five words at a 4-byte-aligned byte address: word 0 = control[31:16] and status[15:0], word 1 = total length[31:16] and data size[15:0], word 2 = pointer to the packet's last descriptor, word 3 = buffer address, word 4 = next-descriptor pointer. Op 0 removes the head packet when status bits [1:0] equal `cmd_own`. The new head is word 4 of the descriptor named by the head's word 2, and `rsp_found`=1 with `rsp_addr`= the old head.
- R4: A dequeue whose condition fails leaves the head unchanged and returns `rsp_found`=0 and `rsp_addr`=0. No dequeue ever writes memory.
- R5: Op 1 removes the head packet under the same rules as R3, but only when status bits [1:0] differ from `cmd_own`.
- R6: Op 2 (rearm) sets bits [1:0] of word 0 at `cmd_desc` to 1 (hardware owned) and keeps the other 30 bits of that word.
- R7: Op 3 (reinitialise) writes word 0 = 0x0000_0001, word 1 = 0x0140_0000 (total length 320, size 0) and word 2 = `cmd_desc` at `cmd_desc`. Words 3 and 4 are left untouched.
- R8: Op 4 (count) follows word 4 links from the head and reports in `rsp_count` how many descriptors come before the terminator. The result is 0 for an empty queue and saturates at all ones.
- R9: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until `mem_ready`. `busy` stays high from acceptance until the cycle after the one-cycle `done` pulse, and `cmd_ready` is high only when the engine is idle.
- R10: `cfg_we` loads head and terminator only when the engine is idle and no command is offered in the same cycle. A configuration write that meets a busy engine or an accepted command has no effect.
- R11: Op codes 5 to 7 finish with `rsp_found`=0, make no memory access and leave the pointers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle; command accepted when both are high |
| cmd_op | input | 3 | Command code (0 dequeue-equal, 1 dequeue-differ, 2 rearm, 3 reinitialise, 4 count) |
| cmd_own | input | 2 | Ownership code compared by dequeues |
| cmd_desc | input | ADDR_W | Descriptor byte address for rearm and reinitialise |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_found | output | 1 | Dequeue removed a packet |
| rsp_addr | output | ADDR_W | Removed descriptor address, 0 when none |
| rsp_count | output | CNT_W | Descriptor count from op 4 |
| cfg_we | input | 1 | Load head and terminator |
| cfg_head | input | ADDR_W | Head value to load |
| cfg_term | input | ADDR_W | Terminator value to load |
| head_o | output | ADDR_W | Current head pointer |
| term_o | output | ADDR_W | Current terminator pointer |
| empty | output | 1 | Head equals terminator |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes this cycle |

## Verification
Two events can arrive in the same cycle: a configuration load and a command acceptance. Both want to set the pointers that the command is about to use. The bench raises `cfg_we` with a different head on the same clock edge as `cmd_valid` for a count, then requires a count taken from the old queue and an unchanged `head_o`. It also pulses `cfg_we` in the middle of a long count and requires the pointers to come out unchanged. Memory latency varies at random, so each state's request is held across stalls of different lengths.

// File: rtl/dq_pkg.sv
package dq_pkg;

   localparam logic [2:0] OP_DEQ_EQ = 3'd0;
   localparam logic [2:0] OP_DEQ_NE = 3'd1;
   localparam logic [2:0] OP_REARM  = 3'd2;
   localparam logic [2:0] OP_REINIT = 3'd3;
   localparam logic [2:0] OP_COUNT  = 3'd4;

   // word offsets inside one descriptor
   localparam logic [2:0] WO_STAT = 3'd0;
   localparam logic [2:0] WO_SIZE = 3'd1;
   localparam logic [2:0] WO_LAST = 3'd2;
   localparam logic [2:0] WO_NEXT = 3'd4;

   localparam logic [1:0]  OWN_HW     = 2'd1;
   localparam logic [15:0] TOTAL_INIT = 16'd320;

   typedef enum logic [3:0] {
      S_IDLE,
      S_DQ_STAT,
      S_DQ_LAST,
      S_DQ_NEXT,
      S_RM_RD,
      S_RM_WR,
      S_RI_W0,
      S_RI_W1,
      S_RI_W2,
      S_CNT,
      S_DONE
   } dq_state_e;

endpackage

// File: rtl/dq_own_cond.sv
module dq_own_cond #(
   parameter int OWN_W = 2
) (
   input  logic [OWN_W-1:0] status_own,
   input  logic [OWN_W-1:0] req_own,
   input  logic             invert,
   output logic             hit
);
   generate
      if (OWN_W < 1) begin : g_bad_w
         $error("dq_own_cond: OWN_W must be at least 1");
      end
   endgenerate

   logic same;
   assign same = (status_own == req_own);
   assign hit  = same ^ invert;
endmodule

// File: rtl/dq_ptr_file.sv
module dq_ptr_file #(
   parameter int          ADDR_W    = 32,
   parameter logic [31:0] RESET_PTR = 32'h0,
   parameter bit          CFG_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_load,
   input  logic [ADDR_W-1:0] cfg_head,
   input  logic [ADDR_W-1:0] cfg_term,
   input  logic              head_load,
   input  logic [ADDR_W-1:0] head_next,
   output logic [ADDR_W-1:0] head,
   output logic [ADDR_W-1:0] term
);
   localparam logic [ADDR_W-1:0] RST_P = RESET_PTR[ADDR_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         head <= RST_P;
      else if (head_load)
         head <= head_next;
      else if (CFG_EN && cfg_load)
         head <= cfg_head;
   end

   generate
      if (CFG_EN) begin : g_term_cfg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               term <= RST_P;
            else if (cfg_load)
               term <= cfg_term;
         end
      end else begin : g_term_fixed
         logic unused_cfg;
         assign unused_cfg = ^cfg_term;
         assign term = RST_P;
      end
   endgenerate
endmodule

// File: rtl/desc_queue_engine.sv
module desc_queue_engine
   import dq_pkg::*;
#(
   parameter int          ADDR_W    = 32,
   parameter int          CNT_W     = 8,
   parameter logic [31:0] RESET_PTR = 32'h0,
   parameter bit          CFG_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [2:0]        cmd_op,
   input  logic [1:0]        cmd_own,
   input  logic [ADDR_W-1:0] cmd_desc,
   output logic              busy,
   output logic              done,
   output logic              rsp_found,
   output logic [ADDR_W-1:0] rsp_addr,
   output logic [CNT_W-1:0]  rsp_count,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_head,
   input  logic [ADDR_W-1:0] cfg_term,
   output logic [ADDR_W-1:0] head_o,
   output logic [ADDR_W-1:0] term_o,
   output logic              empty,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-3:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   input  logic              mem_ready
);
   localparam int             WA_W    = ADDR_W - 2;
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   generate
      if (ADDR_W < 4 || ADDR_W > 32) begin : g_bad_aw
         $error("desc_queue_engine: ADDR_W must lie in 4..32");
      end
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cw
         $error("desc_queue_engine: CNT_W must lie in 1..32");
      end
      if (RESET_PTR[1:0] != 2'b00) begin : g_bad_rst
         $error("desc_queue_engine: RESET_PTR must be word aligned");
      end
   endgenerate

   dq_state_e         state_q;
   logic [2:0]        op_q;
   logic [1:0]        own_q;
   logic [ADDR_W-1:0] tgt_q;
   logic [ADDR_W-1:0] cur_q;
   logic [31:0]       word_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              found_q;

   logic              idle;
   logic              fire;
   logic              own_hit;
   logic              head_load;
   logic              cfg_load;
   logic [ADDR_W-1:0] rd_ptr;
   logic [ADDR_W-1:0] base;
   logic [2:0]        woff;
   logic              unused_rd;

   assign idle      = (state_q == S_IDLE);
   assign fire      = idle && cmd_valid;
   assign cmd_ready = idle;
   assign busy      = !idle;
   assign done      = (state_q == S_DONE);
   assign empty     = (head_o == term_o);
   assign rd_ptr    = mem_rdata[ADDR_W-1:0];
   assign unused_rd = ^mem_rdata;

   assign cfg_load  = cfg_we && idle && !cmd_valid;
   assign head_load = (state_q == S_DQ_NEXT) && mem_ready;

   dq_ptr_file #(
      .ADDR_W   (ADDR_W),
      .RESET_PTR(RESET_PTR),
      .CFG_EN   (CFG_EN)
   ) u_ptrs (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_load (cfg_load),
      .cfg_head (cfg_head),
      .cfg_term (cfg_term),
      .head_load(head_load),
      .head_next(rd_ptr),
      .head     (head_o),
      .term     (term_o)
   );

   dq_own_cond #(.OWN_W(2)) u_cond (
      .status_own(mem_rdata[1:0]),
      .req_own   (own_q),
      .invert    (op_q == OP_DEQ_NE),
      .hit       (own_hit)
   );

   // memory request decode, held steady while the state waits for ready
   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_wdata = '0;
      base      = tgt_q;
      woff      = WO_STAT;
      unique case (state_q)
         S_DQ_STAT: mem_req = 1'b1;
         S_DQ_LAST: begin
            mem_req = 1'b1;
            woff    = WO_LAST;
         end
         S_DQ_NEXT: begin
            mem_req = 1'b1;
            base    = cur_q;
            woff    = WO_NEXT;
         end
         S_RM_RD: mem_req = 1'b1;
         S_RM_WR: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_wdata = {word_q[31:2], OWN_HW};
         end
         S_RI_W0: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_wdata = {16'h0000, 14'h0, OWN_HW};
         end
         S_RI_W1: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            woff      = WO_SIZE;
            mem_wdata = {TOTAL_INIT, 16'h0000};
         end
         S_RI_W2: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            woff      = WO_LAST;
            mem_wdata[ADDR_W-1:0] = tgt_q;
         end
         S_CNT: begin
            mem_req = 1'b1;
            base    = cur_q;
            woff    = WO_NEXT;
         end
         default: ;
      endcase
      mem_addr = base[ADDR_W-1:2] + WA_W'(woff);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         op_q    <= '0;
         own_q   <= '0;
         tgt_q   <= '0;
         cur_q   <= '0;
         word_q  <= '0;
         cnt_q   <= '0;
         found_q <= 1'b0;
      end else begin
         unique case (state_q)
            S_IDLE: if (fire) begin
               op_q    <= cmd_op;
               own_q   <= cmd_own;
               cnt_q   <= '0;
               found_q <= 1'b0;
               cur_q   <= head_o;
               case (cmd_op)
                  OP_DEQ_EQ, OP_DEQ_NE: begin
                     tgt_q   <= head_o;
                     state_q <= empty ? S_DONE : S_DQ_STAT;
                  end
                  OP_REARM: begin
                     tgt_q   <= cmd_desc;
                     state_q <= S_RM_RD;
                  end
                  OP_REINIT: begin
                     tgt_q   <= cmd_desc;
                     state_q <= S_RI_W0;
                  end
                  OP_COUNT: state_q <= empty ? S_DONE : S_CNT;
                  default:  state_q <= S_DONE;
               endcase
            end
            S_DQ_STAT: if (mem_ready)
               state_q <= own_hit ? S_DQ_LAST : S_DONE;
            S_DQ_LAST: if (mem_ready) begin
               cur_q   <= rd_ptr;
               state_q <= S_DQ_NEXT;
            end
            S_DQ_NEXT: if (mem_ready) begin
               found_q <= 1'b1;
               state_q <= S_DONE;
            end
            S_RM_RD: if (mem_ready) begin
               word_q  <= mem_rdata;
               state_q <= S_RM_WR;
            end
            S_RM_WR: if (mem_ready) state_q <= S_DONE;
            S_RI_W0: if (mem_ready) state_q <= S_RI_W1;
            S_RI_W1: if (mem_ready) state_q <= S_RI_W2;
            S_RI_W2: if (mem_ready) state_q <= S_DONE;
            S_CNT: if (mem_ready) begin
               cnt_q <= cnt_q + 1'b1;
               if (rd_ptr == term_o || cnt_q == CNT_MAX - 1'b1)
                  state_q <= S_DONE;
               else
                  cur_q <= rd_ptr;
            end
            S_DONE: state_q <= S_IDLE;
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign rsp_found = found_q;
   assign rsp_addr  = found_q ? tgt_q : '0;
   assign rsp_count = cnt_q;

endmodule

// File: rtl/dq_checker.sv
module dq_checker #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic [2:0]        cmd_op,
   input logic              busy,
   input logic              done,
   input logic              rsp_found,
   input logic [ADDR_W-1:0] head_o,
   input logic [ADDR_W-1:0] term_o,
   input logic              empty,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-3:0] mem_addr,
   input logic [31:0]       mem_wdata,
   input logic              mem_ready
);
   logic [2:0] op_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         op_seen <= 3'd0;
      else if (cmd_valid && cmd_ready)
         op_seen <= cmd_op;
   end

   p_hold_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

   p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> !busy);

   p_done_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   p_empty_deq_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_ready && (cmd_op <= 3'd1) && empty |=> done && !rsp_found && !mem_req);

   p_no_write_deq_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy && (op_seen <= 3'd1 || op_seen == 3'd4) && mem_req |-> !mem_we);

   p_rearm_own_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy && op_seen == 3'd2 && mem_req && mem_we |-> mem_wdata[1:0] == 2'b01);

   p_ptr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy && op_seen >= 3'd2 |=> $stable(head_o) && $stable(term_o));

   p_found_deq_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done && rsp_found |-> op_seen <= 3'd1);

   p_invalid_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
      busy && op_seen >= 3'd5 |-> !mem_req);
endmodule

bind desc_queue_engine dq_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/desc_queue_engine_tb.sv
`timescale 1ns/1ps
module desc_queue_engine_tb;
   localparam int AW = 32;
   localparam int CW = 8;
   localparam logic [31:0] TERM = 32'h20;

   logic clk = 0;
   logic rst_n = 0;
   always #2 clk = ~clk;

   logic          cmd_valid = 0, cmd_ready;
   logic [2:0]    cmd_op = 0;
   logic [1:0]    cmd_own = 0;
   logic [AW-1:0] cmd_desc = 0;
   logic          busy, done, rsp_found;
   logic [AW-1:0] rsp_addr;
   logic [CW-1:0] rsp_count;
   logic          cfg_we = 0;
   logic [AW-1:0] cfg_head = 0, cfg_term = 0;
   logic [AW-1:0] head_o, term_o;
   logic          empty;
   logic          mem_req, mem_we;
   logic [AW-3:0] mem_addr;
   logic [31:0]   mem_wdata;
   logic [31:0]   mem_rdata = 0;
   logic          mem_ready = 0;

   desc_queue_engine #(.ADDR_W(AW), .CNT_W(CW)) u_dut (.*);

   logic [31:0] mem [0:255];
   logic [31:0] emem [0:255];
   int n_acc = 0, n_wr = 0, wait_cnt = 0;
   int n_chk = 0, n_bad = 0;
   logic [31:0] m_head = 0, m_term = 0;

   always @(negedge clk) begin
      if (mem_ready) mem_ready = 0;
      else if (mem_req && rst_n) begin
         if (wait_cnt == 0) begin
            mem_ready = 1;
            mem_rdata = mem[mem_addr[7:0]];
            if (mem_we) begin
               mem[mem_addr[7:0]] = mem_wdata;
               n_wr++;
            end
            n_acc++;
            wait_cnt = $urandom % 3;
         end else wait_cnt--;
      end
   end

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int wi(logic [31:0] p);
      return int'((p >> 2) & 32'hff);
   endfunction

   // run one command; returns response fields and access counts
   task automatic run_cmd(logic [2:0] op, logic [1:0] own, logic [31:0] d,
                          output bit f, output logic [31:0] a, output logic [7:0] c,
                          output int acc, output int wr);
      int a0 = n_acc, w0 = n_wr;
      @(negedge clk);
      cmd_valid = 1; cmd_op = op; cmd_own = own; cmd_desc = d;
      @(negedge clk);
      cmd_valid = 0;
      for (int k = 0; k < 2000 && !done; k++) @(negedge clk);
      f = rsp_found; a = rsp_addr; c = rsp_count;
      acc = n_acc - a0; wr = n_wr - w0;
      @(negedge clk);
   endtask

   task automatic load_cfg(logic [31:0] h, logic [31:0] t);
      @(negedge clk);
      cfg_we = 1; cfg_head = h; cfg_term = t;
      @(negedge clk);
      cfg_we = 0;
      m_head = h; m_term = t;
      chk(head_o == h && term_o == t, "R10 cfg load", head_o, h);
   endtask

   // descriptors at TERM + 20*i; slot 0 is the terminator
   function automatic logic [31:0] slot(int i);
      return TERM + 32'(20 * i);
   endfunction

   task automatic build_q(int ndesc);
      int i = 1;
      for (int w = 0; w < 256; w++) mem[w] = $urandom;
      while (i <= ndesc) begin
         int k = 1 + ($urandom % 3);
         if (i + k - 1 > ndesc) k = ndesc - i + 1;
         for (int j = 0; j < k; j++) begin
            int s = i + j;
            mem[wi(slot(s))] = {$urandom(), 2'b00} | 32'($urandom % 3);
            mem[wi(slot(s)) + 2] = (j == 0) ? slot(i + k - 1) : slot(s);
            mem[wi(slot(s)) + 4] = (s == ndesc) ? TERM : slot(s + 1);
         end
         i += k;
      end
      load_cfg(ndesc == 0 ? TERM : slot(1), TERM);
   endtask

   // expected result of one command on emem / m_head
   task automatic model(logic [2:0] op, logic [1:0] own, logic [31:0] d,
                        output bit f, output logic [31:0] a, output logic [7:0] c,
                        output int acc, output int wr);
      f = 0; a = 0; c = 0; acc = 0; wr = 0;
      case (op)
         3'd0, 3'd1: if (m_head != m_term) begin
            bit hit = (emem[wi(m_head)][1:0] == own) ^ (op == 3'd1);
            acc = 1;
            if (hit) begin
               logic [31:0] last = emem[wi(m_head) + 2];
               f = 1; a = m_head; acc = 3;
               m_head = emem[wi(last) + 4];
            end
         end
         3'd2: begin
            emem[wi(d)] = {emem[wi(d)][31:2], 2'b01};
            acc = 2; wr = 1;
         end
         3'd3: begin
            emem[wi(d)] = 32'h0000_0001;
            emem[wi(d) + 1] = 32'h0140_0000;
            emem[wi(d) + 2] = d;
            acc = 3; wr = 3;
         end
         3'd4: begin
            logic [31:0] p = m_head;
            while (p != m_term && c != 8'hff) begin
               p = emem[wi(p) + 4];
               c++; acc++;
            end
         end
         default: ;
      endcase
   endtask

   task automatic do_check(logic [2:0] op, logic [1:0] own, logic [31:0] d, string tag);
      bit f, ef; logic [31:0] a, ea; logic [7:0] c, ec; int acc, eacc, wr, ewr;
      bit same = 1;
      for (int w = 0; w < 256; w++) emem[w] = mem[w];
      model(op, own, d, ef, ea, ec, eacc, ewr);
      run_cmd(op, own, d, f, a, c, acc, wr);
      chk(f == ef && a == ea, {tag, " response"}, a, ea);
      chk(head_o == m_head, {tag, " head"}, head_o, m_head);
      chk(acc == eacc && wr == ewr, {tag, " accesses"}, 32'(acc), 32'(eacc));
      if (op == 3'd4) chk(c == ec, {tag, " count"}, 32'(c), 32'(ec));
      for (int w = 0; w < 256; w++) if (mem[w] !== emem[w]) same = 0;
      chk(same, {tag, " memory image"}, 0, 0);
   endtask

   function automatic string tag_of(logic [2:0] op);
      case (op)
         3'd0: return "R3 deq-equal (R4 on miss)";
         3'd1: return "R5 deq-differ (R4 on miss)";
         3'd2: return "R6 rearm";
         3'd3: return "R7 reinit";
         3'd4: return "R8 count";
         default: return "R11 invalid op";
      endcase
   endfunction

   initial begin
      #790000;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      for (int w = 0; w < 256; w++) mem[w] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(head_o == 0 && term_o == 0, "R1 reset pointers", head_o, 0);
      chk(empty && !busy && cmd_ready, "R1 reset flags", {empty, busy, cmd_ready}, 3'b101);

      // R2 empty dequeue: no access
      do_check(3'd0, 2'd0, 0, "R2 empty deq");
      do_check(3'd1, 2'd3, 0, "R2 empty deq-differ");
      do_check(3'd4, 2'd0, 0, "R8 empty count");

      // R10 config and command in the same cycle: command wins
      build_q(5);
      @(negedge clk);
      cfg_we = 1; cfg_head = slot(3); cfg_term = slot(2);
      cmd_valid = 1; cmd_op = 3'd4;
      @(negedge clk);
      cfg_we = 0; cmd_valid = 0;
      for (int k = 0; k < 200 && !done; k++) @(negedge clk);
      chk(rsp_count == 5, "R10 same-cycle count", 32'(rsp_count), 5);
      @(negedge clk);
      chk(head_o == slot(1) && term_o == TERM, "R10 same-cycle cfg dropped", head_o, slot(1));

      // R10 config during a busy count
      @(negedge clk);
      cmd_valid = 1; cmd_op = 3'd4;
      @(negedge clk);
      cmd_valid = 0;
      @(negedge clk);
      cfg_we = 1; cfg_head = slot(4); cfg_term = slot(4);
      @(negedge clk);
      cfg_we = 0;
      for (int k = 0; k < 200 && !done; k++) @(negedge clk);
      @(negedge clk);
      chk(head_o == slot(1) && term_o == TERM, "R10 busy cfg ignored", head_o, slot(1));

      // R11 invalid codes
      do_check(3'd5, 2'd0, slot(1), "R11 op5");
      do_check(3'd7, 2'd1, slot(2), "R11 op7");

      // R6/R7 directed on queue head, then R3 hit and miss
      do_check(3'd2, 2'd0, slot(2), "R6 rearm directed");
      do_check(3'd3, 2'd0, slot(3), "R7 reinit directed");
      do_check(3'd0, mem[wi(slot(1))][1:0], 0, "R3 deq hit directed");
      do_check(3'd0, mem[wi(head_o)][1:0] ^ 2'd1, 0, "R4 deq miss directed");
      do_check(3'd1, mem[wi(head_o)][1:0], 0, "R5 deq-differ miss directed");

      // random rounds (R9 stalls come from random memory latency)
      for (int r = 0; r < 40; r++) begin
         build_q($urandom % 11);
         for (int n = 0; n < 8; n++) begin
            logic [2:0] op = 3'($urandom % 8);
            logic [1:0] own = 2'($urandom % 4);
            logic [31:0] d = slot($urandom % 11);
            if (op >= 3'd5 && ($urandom % 2)) op = 3'($urandom % 2);
            do_check(op, own, d, tag_of(op));
         end
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule